// File: doc/BRIEF.md
# Linked-List DMA Element Transfer Engine

This engine moves data for one DMA channel at a time. A scheduler hands it a channel together with that channel's source address, destination address, next-descriptor pointer and control word. The engine reads one element from the source and writes it to the destination. It then steps the addresses when their increment bits are set and counts the transfer down by one. Finally it returns the updated channel context to the register bank in a single write-back cycle.

When the count runs out, the engine looks at the next-descriptor pointer. If the pointer is nonzero, the engine reads a four-word descriptor from memory and loads a new source, destination, control word and pointer from it. This chains transfer blocks together with no processor involvement. If the pointer is zero, the engine tells the register bank to switch the channel off. In either case, if the finishing control word asks for it, the engine pulses a terminal-count flag for that channel.

All memory traffic goes through one valid/ready port that carries at most one access per cycle. Reads return their data on the cycle of the handshake.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset the engine is idle. `gnt_ready` is 1 and `busy`, `mem_valid` and `wb_valid` are 0.
- R2: A grant with a nonzero count (control bits [11:0]) produces exactly two memory accesses. The first is a read at the source address with `mem_size` equal to control[20:18]. The second is a write at the destination address with `mem_size` equal to control[23:21], and it carries the data that the read returned.
- R3: The written-back source address is the granted source plus 2^control[20:18] when control bit 26 is 1. It is unchanged when bit 26 is 0.
- R4: The written-back destination address is the granted destination plus 2^control[23:21] when control bit 27 is 1. It is unchanged when bit 27 is 0.
- R5: The written-back control word holds the count minus one in bits [11:0] and keeps bits [31:12] unchanged. When the count does not reach zero, `wb_chan_off` is 0, no terminal-count flag pulses, and the pointer is written back unchanged. `wb_valid` lasts exactly one cycle for each grant.
- R6: When the count reaches zero and the pointer P is nonzero, the engine issues four word reads (`mem_size`=2) in this order: P+0, P+4, P+12, P+8. The write-back then carries source = word(P+0), destination = word(P+4), control = word(P+12), pointer = word(P+8), and `wb_chan_off` = 0.
- R7: When the count reaches zero and the pointer is zero, the engine issues no descriptor reads. The write-back has `wb_chan_off` = 1, a zero pointer and a zero count.
- R8: When a transfer completes and control bit 31 of the finishing control word is 1, `tc_pulse` bit `wb_ch` is 1 during the write-back cycle. `tc_pulse` is zero at all other times and is never set for more than one channel.
- R9: A grant whose count is already zero makes no element access. The engine goes straight to the completion handling of R6, R7 and R8, and the addresses are not stepped.
- R10: From acceptance until write-back, `busy` is 1, `busy_ch` is the granted channel and `gnt_ready` is 0. A grant offered in that time is ignored.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, the request (`mem_valid`, `mem_we`, `mem_addr`) stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_valid | input | 1 | Scheduler offers a channel |
| gnt_ready | output | 1 | Engine idle and able to accept |
| gnt_ch | input | CHW | Granted channel index |
| gnt_src | input | 32 | Channel source address |
| gnt_dst | input | 32 | Channel destination address |
| gnt_lli | input | 32 | Channel next-descriptor pointer |
| gnt_ctrl | input | 32 | Channel control word |
| busy | output | 1 | Engine working on a channel |
| busy_ch | output | CHW | Channel being worked on |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 3 | log2 of the access size in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid on handshake |
| wb_valid | output | 1 | One-cycle context write-back |
| wb_ch | output | CHW | Channel being written back |
| wb_src | output | 32 | Updated source address |
| wb_dst | output | 32 | Updated destination address |
| wb_lli | output | 32 | Updated descriptor pointer |
| wb_ctrl | output | 32 | Updated control word |
| wb_chan_off | output | 1 | Clear the channel enable |
| tc_pulse | output | NCH | Terminal-count flag per channel |

## Verification
The bench goes after the count boundaries: a count of one, which completes after one element, and a count of zero at grant, which must skip the element access. A design that got these wrong would move an extra element or wrap the count to 4095. The bench also checks the descriptor read order and the word each field comes from. Swapping the +8 and +12 fetches, or overwriting the pointer before the last fetch, would show up as a wrong address or a crossed control and pointer. It checks that the terminal-count flag follows bit 31 of the finishing control word and not the freshly loaded one. Grants offered while the engine is busy and random memory stalls expose designs that take a second channel or drift the request before it is accepted.

// File: rtl/dll_pkg.sv
package dll_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 12;
    localparam int SW_LO    = 18;
    localparam int DW_LO    = 21;
    localparam int SINC_BIT = 26;
    localparam int DINC_BIT = 27;
    localparam int TC_BIT   = 31;

    // descriptor word offsets, fetched in the order SRC, DST, CTRL, LINK
    localparam logic [WORD_W-1:0] OFS_SRC  = 32'd0;
    localparam logic [WORD_W-1:0] OFS_DST  = 32'd4;
    localparam logic [WORD_W-1:0] OFS_LINK = 32'd8;
    localparam logic [WORD_W-1:0] OFS_CTRL = 32'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_F_SRC,
        ST_F_DST,
        ST_F_CTRL,
        ST_F_LINK,
        ST_WB
    } eng_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] lli;
        logic [WORD_W-1:0] ctrl;
    } chan_ctx_t;

    function automatic logic [WORD_W-1:0] step_addr(
        input logic [WORD_W-1:0] a,
        input logic [2:0]        wcode,
        input logic              en
    );
        return en ? (a + (WORD_W'(1) << wcode)) : a;
    endfunction

endpackage

// File: rtl/dll_elem_step.sv
module dll_elem_step
    import dll_pkg::*;
(
    input  chan_ctx_t cur,
    output chan_ctx_t nxt,
    output logic      last
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt      = cur.ctrl[CNT_W-1:0];
        nxt.src  = step_addr(cur.src, cur.ctrl[SW_LO+:3], cur.ctrl[SINC_BIT]);
        nxt.dst  = step_addr(cur.dst, cur.ctrl[DW_LO+:3], cur.ctrl[DINC_BIT]);
        nxt.lli  = cur.lli;
        nxt.ctrl = {cur.ctrl[WORD_W-1:CNT_W], cnt - CNT_W'(1)};
        last     = (cnt == CNT_W'(1));
    end
endmodule

// File: rtl/dll_mem_req.sv
module dll_mem_req
    import dll_pkg::*;
(
    input  eng_st_e           st,
    input  chan_ctx_t         ctx,
    input  logic [WORD_W-1:0] hold,
    output logic              req_valid,
    output logic              req_we,
    output logic [WORD_W-1:0] req_addr,
    output logic [2:0]        req_size,
    output logic [WORD_W-1:0] req_wdata
);
    always_comb begin
        req_valid = 1'b1;
        req_we    = 1'b0;
        req_addr  = '0;
        req_size  = 3'd2;
        req_wdata = hold;
        unique case (st)
            ST_RD: begin
                req_addr = ctx.src;
                req_size = ctx.ctrl[SW_LO+:3];
            end
            ST_WR: begin
                req_we   = 1'b1;
                req_addr = ctx.dst;
                req_size = ctx.ctrl[DW_LO+:3];
            end
            ST_F_SRC:  req_addr = ctx.lli + OFS_SRC;
            ST_F_DST:  req_addr = ctx.lli + OFS_DST;
            ST_F_CTRL: req_addr = ctx.lli + OFS_CTRL;
            ST_F_LINK: req_addr = ctx.lli + OFS_LINK;
            default:   req_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dll_tc_decode.sv
module dll_tc_decode #(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           fire,
    input  logic [CHW-1:0] ch,
    output logic [NCH-1:0] flags
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign flags[i] = fire && (ch == CHW'(i));
    end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
    import dll_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_valid,
    output logic              gnt_ready,
    input  logic [CHW-1:0]    gnt_ch,
    input  logic [WORD_W-1:0] gnt_src,
    input  logic [WORD_W-1:0] gnt_dst,
    input  logic [WORD_W-1:0] gnt_lli,
    input  logic [WORD_W-1:0] gnt_ctrl,
    output logic              busy,
    output logic [CHW-1:0]    busy_ch,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [CHW-1:0]    wb_ch,
    output logic [WORD_W-1:0] wb_src,
    output logic [WORD_W-1:0] wb_dst,
    output logic [WORD_W-1:0] wb_lli,
    output logic [WORD_W-1:0] wb_ctrl,
    output logic              wb_chan_off,
    output logic [NCH-1:0]    tc_pulse
);
    eng_st_e           st;
    chan_ctx_t         ctx;
    chan_ctx_t         stepped;
    logic              step_last;
    logic [CHW-1:0]    cur_ch;
    logic [WORD_W-1:0] hold;
    logic              fin_tc;
    logic              fin_off;
    logic              hs;
    logic              gnt_cnt_zero;

    dll_elem_step u_step (
        .cur  (ctx),
        .nxt  (stepped),
        .last (step_last)
    );

    dll_mem_req u_req (
        .st        (st),
        .ctx       (ctx),
        .hold      (hold),
        .req_valid (mem_valid),
        .req_we    (mem_we),
        .req_addr  (mem_addr),
        .req_size  (mem_size),
        .req_wdata (mem_wdata)
    );

    dll_tc_decode #(.NCH(NCH)) u_tc (
        .fire  (wb_valid && fin_tc),
        .ch    (cur_ch),
        .flags (tc_pulse)
    );

    assign hs           = mem_valid && mem_ready;
    assign gnt_ready    = (st == ST_IDLE);
    assign busy         = (st != ST_IDLE);
    assign busy_ch      = cur_ch;
    assign gnt_cnt_zero = (gnt_ctrl[CNT_W-1:0] == '0);

    assign wb_valid    = (st == ST_WB);
    assign wb_ch       = cur_ch;
    assign wb_src      = ctx.src;
    assign wb_dst      = ctx.dst;
    assign wb_lli      = ctx.lli;
    assign wb_ctrl     = ctx.ctrl;
    assign wb_chan_off = fin_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctx     <= '0;
            cur_ch  <= '0;
            hold    <= '0;
            fin_tc  <= 1'b0;
            fin_off <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (gnt_valid) begin
                    ctx     <= '{src: gnt_src, dst: gnt_dst, lli: gnt_lli, ctrl: gnt_ctrl};
                    cur_ch  <= gnt_ch;
                    fin_tc  <= gnt_cnt_zero && gnt_ctrl[TC_BIT];
                    fin_off <= gnt_cnt_zero && (gnt_lli == '0);
                    if (!gnt_cnt_zero)       st <= ST_RD;
                    else if (gnt_lli != '0)  st <= ST_F_SRC;
                    else                     st <= ST_WB;
                end
                ST_RD: if (hs) begin
                    hold <= mem_rdata;
                    st   <= ST_WR;
                end
                ST_WR: if (hs) begin
                    ctx    <= stepped;
                    fin_tc <= step_last && ctx.ctrl[TC_BIT];
                    if (step_last && (ctx.lli != '0)) begin
                        st <= ST_F_SRC;
                    end else begin
                        fin_off <= step_last;
                        st      <= ST_WB;
                    end
                end
                ST_F_SRC: if (hs) begin
                    ctx.src <= mem_rdata;
                    st      <= ST_F_DST;
                end
                ST_F_DST: if (hs) begin
                    ctx.dst <= mem_rdata;
                    st      <= ST_F_CTRL;
                end
                ST_F_CTRL: if (hs) begin
                    ctx.ctrl <= mem_rdata;
                    st       <= ST_F_LINK;
                end
                ST_F_LINK: if (hs) begin
                    ctx.lli <= mem_rdata;
                    st      <= ST_WB;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !gnt_ready); // R10
    AST_BUSY_CH_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && !wb_valid |=> busy && $stable(busy_ch)); // R10
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid); // R5
    AST_TC_IN_WB: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse != '0) |-> wb_valid); // R8
    AST_TC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_pulse)); // R8
    AST_OFF_CLEAN: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_chan_off |-> (wb_lli == '0) && (wb_ctrl[CNT_W-1:0] == '0)); // R7
    AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
        gnt_ready |-> !mem_valid); // R1

endmodule

// File: tb/dma_ll_engine_tb.sv
module dma_ll_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CHW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic gnt_valid = 1'b0, gnt_ready;
    logic [CHW-1:0] gnt_ch = '0;
    logic [31:0] gnt_src = '0, gnt_dst = '0, gnt_lli = '0, gnt_ctrl = '0;
    logic busy; logic [CHW-1:0] busy_ch;
    logic mem_valid, mem_ready = 1'b0, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0] mem_size;
    logic wb_valid, wb_chan_off;
    logic [CHW-1:0] wb_ch;
    logic [31:0] wb_src, wb_dst, wb_lli, wb_ctrl;
    logic [NCH-1:0] tc_pulse;

    dma_ll_engine #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
        .gnt_ch(gnt_ch), .gnt_src(gnt_src), .gnt_dst(gnt_dst), .gnt_lli(gnt_lli),
        .gnt_ctrl(gnt_ctrl), .busy(busy), .busy_ch(busy_ch),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_ch(wb_ch),
        .wb_src(wb_src), .wb_dst(wb_dst), .wb_lli(wb_lli), .wb_ctrl(wb_ctrl),
        .wb_chan_off(wb_chan_off), .tc_pulse(tc_pulse)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];

    logic [31:0] lg_addr [16];
    logic        lg_we   [16];
    logic [2:0]  lg_size [16];
    logic [31:0] lg_data [16];
    int lg_n = 0;
    logic stall_en = 1'b0;

    // memory model: pick ready first, then log and apply the accepted access
    always @(negedge clk) begin
        mem_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
        if (!rst && mem_valid && mem_ready) begin
            if (lg_n < 16) begin
                lg_addr[lg_n] = mem_addr;
                lg_we[lg_n]   = mem_we;
                lg_size[lg_n] = mem_size;
                lg_data[lg_n] = mem_wdata;
            end
            lg_n = lg_n + 1;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit tc, input bit di, input bit si,
                                            input logic [2:0] w, input logic [11:0] cnt);
        logic [31:0] c;
        c = $urandom;
        c[31] = tc; c[27] = di; c[26] = si;
        c[23:21] = w; c[20:18] = w; c[11:0] = cnt;
        return c;
    endfunction

    task automatic run_grant(input logic [CHW-1:0] ch, input logic [31:0] s,
                             input logic [31:0] d, input logic [31:0] l, input logic [31:0] c);
        logic [31:0] e_addr [6];
        logic        e_we   [6];
        logic [2:0]  e_sz   [6];
        int en;
        logic [31:0] xs, xd, xl, xc, data0;
        bit xoff, xtc, done;
        logic [11:0] cnt;
        int guard;
        cnt = c[11:0];
        en = 0; xs = s; xd = d; xl = l; xc = c; xoff = 0; xtc = 0; done = 0;
        data0 = mem[s[9:2]];
        if (cnt != 0) begin
            e_addr[0] = s; e_we[0] = 0; e_sz[0] = c[20:18];
            e_addr[1] = d; e_we[1] = 1; e_sz[1] = c[23:21];
            en = 2;
            if (c[26]) xs = s + (32'd1 << c[20:18]);
            if (c[27]) xd = d + (32'd1 << c[23:21]);
            xc = {c[31:12], cnt - 12'd1};
            done = (cnt == 12'd1);
        end else begin
            done = 1;
        end
        if (done) begin
            xtc = c[31];
            if (l != 0) begin
                e_addr[en] = l;      e_we[en] = 0; e_sz[en] = 3'd2; en++;
                e_addr[en] = l + 4;  e_we[en] = 0; e_sz[en] = 3'd2; en++;
                e_addr[en] = l + 12; e_we[en] = 0; e_sz[en] = 3'd2; en++;
                e_addr[en] = l + 8;  e_we[en] = 0; e_sz[en] = 3'd2; en++;
                xs = mem[l[9:2]]; xd = mem[l[9:2] + 8'd1];
                xl = mem[l[9:2] + 8'd2]; xc = mem[l[9:2] + 8'd3];
            end else begin
                xoff = 1;
            end
        end

        @(negedge clk);
        lg_n = 0;
        gnt_ch = ch; gnt_src = s; gnt_dst = d; gnt_lli = l; gnt_ctrl = c;
        gnt_valid = 1'b1;
        @(negedge clk);
        chk(busy && busy_ch == ch && !gnt_ready, "R10 busy after accept", {28'd0, busy, busy_ch}, {28'd0, 1'b1, ch});
        // offer a rival grant while busy; it must be ignored
        gnt_ch = ch + 3'd1; gnt_src = 32'h0000_0100; gnt_dst = 32'h0000_0180;
        gnt_lli = 32'h0; gnt_ctrl = 32'h8000_0001;
        guard = 0;
        while (!wb_valid && guard < 200) begin
            if (gnt_ready) chk(0, "R10 ready while busy", 1, 0);
            @(negedge clk);
            guard++;
        end
        gnt_valid = 1'b0;
        chk(wb_valid, "R5 write-back seen", {31'd0, wb_valid}, 1);
        chk(wb_ch == ch, "R10 wb channel", wb_ch, ch);
        chk(wb_src == xs, "R3 wb source", wb_src, xs);
        chk(wb_dst == xd, "R4 wb destination", wb_dst, xd);
        chk(wb_ctrl == xc, (cnt == 0 || !done) ? "R5 wb control" : "R6 wb control", wb_ctrl, xc);
        chk(wb_lli == xl, xoff ? "R7 wb pointer" : "R6 wb pointer", wb_lli, xl);
        chk(wb_chan_off == xoff, "R7 channel off flag", wb_chan_off, xoff);
        chk(tc_pulse == (xtc ? (8'd1 << ch) : 8'd0), "R8 tc pulse", tc_pulse, xtc ? (8'd1 << ch) : 8'd0);
        chk(lg_n == en, cnt == 0 ? "R9 access count" : "R2 access count", lg_n, en);
        for (int i = 0; i < en && i < lg_n; i++) begin
            chk(lg_addr[i] == e_addr[i] && lg_we[i] == e_we[i] && lg_size[i] == e_sz[i],
                i < 2 && cnt != 0 ? "R2 access" : "R6 descriptor access",
                lg_addr[i], e_addr[i]);
        end
        if (cnt != 0) chk(lg_data[1] == data0, "R2 write data", lg_data[1], data0);
        @(negedge clk);
        chk(!wb_valid && gnt_ready && tc_pulse == 0, "R5 single write-back", {31'd0, wb_valid}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(gnt_ready && !busy && !mem_valid && !wb_valid, "R1 reset state",
            {28'd0, gnt_ready, busy, mem_valid, wb_valid}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        chk(gnt_ready && !busy && !mem_valid && !wb_valid, "R1 idle after reset",
            {28'd0, gnt_ready, busy, mem_valid, wb_valid}, 32'h8);

        // directed corners
        run_grant(3'd1, 32'h10, 32'h120, 32'h0,   mk_ctrl(1, 1, 1, 3'd2, 12'd3));  // R3 R4 R5
        run_grant(3'd2, 32'h20, 32'h140, 32'h0,   mk_ctrl(1, 0, 0, 3'd0, 12'd5));  // no increments
        run_grant(3'd3, 32'h30, 32'h160, 32'h0,   mk_ctrl(1, 1, 0, 3'd1, 12'd1));  // R7 completion
        run_grant(3'd4, 32'h40, 32'h180, 32'h240, mk_ctrl(1, 0, 1, 3'd2, 12'd1));  // R6 chain
        run_grant(3'd5, 32'h50, 32'h1a0, 32'h0,   mk_ctrl(1, 1, 1, 3'd2, 12'd0));  // R9 zero, off
        run_grant(3'd6, 32'h60, 32'h1c0, 32'h2f0, mk_ctrl(0, 1, 1, 3'd2, 12'd0));  // R9 zero, chain
        run_grant(3'd7, 32'h70, 32'h1e0, 32'h0,   mk_ctrl(0, 1, 1, 3'd0, 12'd1));  // R8 no tc

        stall_en = 1'b1;  // R11 exercised under random stalls
        for (int k = 0; k < 60; k++) begin
            logic [31:0] s, d, l;
            s = {22'd0, 6'($urandom), 2'b00} + 32'h0;
            d = {22'd0, 6'($urandom), 2'b00} + 32'h100;
            l = (($urandom % 2) == 0) ? 32'h0 : (32'h200 + {23'd0, 5'($urandom), 4'h0});
            run_grant(3'($urandom), s, d, l,
                      mk_ctrl(1'($urandom), 1'($urandom), 1'($urandom),
                              3'($urandom % 3), 12'($urandom % 4)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule